// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Trigger Flags

This block sits between a CPU register port and a serial bus engine. It holds one 16-entry byte queue for outgoing data and one for incoming data. The CPU fills the transmit queue and drains the receive queue through a single data-port address. The bus engine takes bytes from the transmit queue and delivers received bytes into the receive queue.

A control register flushes either queue and sets the trigger level for each one. The transmit level is a two-bit code that selects a threshold of remaining bytes. The receive level is a count minus one. A status register holds three sticky flags: transmit queue low, receive queue ready, and transmit end. Software clears a flag by writing 0 to its bit. An enable register decides which flags drive the single interrupt output. Two read-only registers report how many bytes each queue holds.

Top module: `xfer_fifo_pair`

## Requirements
- R1: Each queue holds up to 16 bytes. Its fill count (0 to 16) reads at select 4 (receive) and select 5 (transmit), zero-extended to 8 bits. Both counts read 0 after reset.
- R2: A write to select 0 (data port) pushes `reg_wdata` into the transmit queue. A write while that queue holds 16 bytes is dropped and leaves the count at 16.
- R3: With `reg_sel` = 0, `reg_rdata` shows the oldest receive byte, and a read (`reg_rd`) pops it at the clock edge. Bytes come out in arrival order. A read of an empty queue returns 0 and leaves the count at 0.
- R4: A write to select 1 (control) with bit 0 set empties the transmit queue, and with bit 1 set empties the receive queue. The other queue is unaffected. Bits 0 and 1 read back as 0.
- R5: Control bits [7:4] hold n. Status bit 1 (receive ready) is set in the cycle after the receive count is at least n+1.
- R6: Control bits [3:2] hold the transmit code. Codes 0, 1, 2 and 3 set status bit 0 (transmit low) when the transmit count is at most 8, 4, 2 and 0 respectively. The flag is set in the cycle after that condition holds.
- R7: Status bit 2 (transmit end) is set when `tx_shift_done` pulses while the transmit queue is empty. It stays set when new bytes are pushed, until software clears it.
- R8: A write to select 2 (status) clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. A flag whose set condition still holds is set again on the next edge.
- R9: `fifo_irq` is high while any status flag is set together with its bit in the enable register (select 3, bits [2:0] in the same bit order as the status register).
- R10: The bus side sees `tx_valid` high while the transmit queue is not empty, with `tx_byte` the oldest byte. `tx_take` pops that byte. `rx_push` stores `rx_byte` in the receive queue and is dropped when that queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select: 0 data, 1 control, 2 status, 3 enable, 4 receive count, 5 transmit count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at select 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| fifo_irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Bus engine pops one transmit byte |
| rx_push | input | 1 | Bus engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| tx_shift_done | input | 1 | Pulse when a byte has fully left the shifter |

## Verification
Pushes, pops, flushes and register writes take effect at the edge on which they are strobed. The counts, the data-port head and `tx_byte` can therefore be read in the following low clock phase. The status flags sample the counts registered at that edge and appear one edge later. `fifo_irq` follows them combinationally. For this reason every flag check first writes 0 to the status register, lets one idle edge pass, and only then reads the register. Because of that ordering, the expected flag value depends only on the counts the bench models for the current moment.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_IEN   = 3'd3,
        SEL_RXCNT = 3'd4,
        SEL_TXCNT = 3'd5
    } reg_sel_e;

    // bit order matters: status and enable registers share it
    typedef struct packed {
        logic tx_end;
        logic rx_ready;
        logic tx_low;
    } fifo_flags_t;

    typedef struct packed {
        logic [3:0] rx_level;
        logic [1:0] tx_code;
    } trig_cfg_t;

    function automatic logic [CNT_W-1:0] tx_limit(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(8);
            2'd1:    return CNT_W'(4);
            2'd2:    return CNT_W'(2);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    assign head = (count == '0) ? '0 : mem[rp];
endmodule

// File: rtl/xfer_fifo_flags.sv
module xfer_fifo_flags
    import xfer_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  trig_cfg_t        cfg,
    input  logic             shift_done,
    input  logic             clr_we,
    input  logic [2:0]       clr_keep,
    output fifo_flags_t      flags
);
    fifo_flags_t set_now;
    fifo_flags_t kept;

    always_comb begin
        set_now.tx_low   = tx_count <= tx_limit(cfg.tx_code);
        set_now.rx_ready = rx_count >= (CNT_W'(cfg.rx_level) + 1'b1);
        set_now.tx_end   = shift_done && (tx_count == '0);
        kept = clr_we ? (flags & fifo_flags_t'(clr_keep)) : flags;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= kept | set_now;
    end
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import xfer_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        fifo_irq,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_take,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        tx_shift_done
);
    trig_cfg_t        cfg_q;
    logic [2:0]       ien_q;
    fifo_flags_t      flags_q;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic [BYTE_W-1:0] rx_head;
    logic             wr_data, wr_ctrl, wr_stat, wr_ien, rd_data;
    logic             tx_flush, rx_flush;

    assign wr_data  = reg_wr && (reg_sel == SEL_DATA);
    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
    assign wr_ien   = reg_wr && (reg_sel == SEL_IEN);
    assign rd_data  = reg_rd && (reg_sel == SEL_DATA);
    assign tx_flush = wr_ctrl && reg_wdata[0];
    assign rx_flush = wr_ctrl && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_ctrl) cfg_q <= '{rx_level: reg_wdata[7:4], tx_code: reg_wdata[3:2]};
            if (wr_ien)  ien_q <= reg_wdata[2:0];
        end
    end

    xfer_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(wr_data), .din(reg_wdata),
        .pop(tx_take), .head(tx_byte), .count(tx_cnt)
    );

    xfer_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(rx_push), .din(rx_byte),
        .pop(rd_data), .head(rx_head), .count(rx_cnt)
    );

    xfer_fifo_flags u_flags (
        .clk(clk), .rst(rst),
        .tx_count(tx_cnt), .rx_count(rx_cnt), .cfg(cfg_q),
        .shift_done(tx_shift_done),
        .clr_we(wr_stat), .clr_keep(reg_wdata[2:0]),
        .flags(flags_q)
    );

    assign tx_valid = tx_cnt != '0;
    assign fifo_irq = |(flags_q & fifo_flags_t'(ien_q));

    always_comb begin
        case (reg_sel)
            SEL_DATA:  reg_rdata = rx_head;
            SEL_CTRL:  reg_rdata = {cfg_q.rx_level, cfg_q.tx_code, 2'b00};
            SEL_STAT:  reg_rdata = {5'b0, flags_q};
            SEL_IEN:   reg_rdata = {5'b0, ien_q};
            SEL_RXCNT: reg_rdata = 8'(rx_cnt);
            SEL_TXCNT: reg_rdata = 8'(tx_cnt);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_fifo_pair_chk.sv
module xfer_fifo_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic       tx_take,
    input logic       rx_push,
    input logic [4:0] tx_count,
    input logic [4:0] rx_count,
    input logic [2:0] flags,
    input logic [2:0] ien,
    input logic       fifo_irq
);
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= 5'd16) && (rx_count <= 5'd16));

    a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
        (tx_count == 5'd16 && reg_wr && reg_sel == 3'd0 && !tx_take) |=> (tx_count == 5'd16));

    a_r3_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rx_count == 5'd0 && reg_rd && reg_sel == 3'd0 && !rx_push) |=> (rx_count == 5'd0));

    a_r4_tx_flush: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd1 && reg_wdata[0]) |=> (tx_count == 5'd0));

    a_r7_end_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !(reg_wr && reg_sel == 3'd2 && !reg_wdata[2])) |=> flags[2]);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (ien == 3'd0) |-> !fifo_irq);
endmodule

bind xfer_fifo_pair xfer_fifo_pair_chk u_chk (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .tx_take(tx_take), .rx_push(rx_push),
    .tx_count(tx_cnt), .rx_count(rx_cnt), .flags(flags_q), .ien(ien_q),
    .fifo_irq(fifo_irq)
);

// File: tb/xfer_fifo_pair_bench.sv
module xfer_fifo_pair_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fifo_irq, tx_valid;
    logic [7:0] tx_byte;
    logic       tx_take = 1'b0, rx_push = 1'b0, tx_shift_done = 1'b0;
    logic [7:0] rx_byte = '0;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2.5 clk = ~clk;

    xfer_fifo_pair u_xfer_fifo_pair (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_irq(fifo_irq),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_shift_done(tx_shift_done)
    );

    function automatic int lim_of(input int code);
        case (code)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] flags_exp(input int code, input int lvl, input bit tend);
        return {5'b0, tend, (rxq.size() >= lvl + 1), (txq.size() <= lim_of(code))};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic cpu_push(input logic [7:0] b);
        wr(3'd0, b);
        if (txq.size() < 16) txq.push_back(b);
    endtask

    task automatic eng_rx(input logic [7:0] b);
        @(negedge clk); rx_push = 1'b1; rx_byte = b;
        @(negedge clk); rx_push = 1'b0;
        if (rxq.size() < 16) rxq.push_back(b);
    endtask

    task automatic eng_take(input string req);
        logic [7:0] e;
        @(negedge clk);
        e = txq.pop_front();
        chk({req, " tx_valid"}, {7'b0, tx_valid}, 8'd1);
        chk({req, " tx_byte"}, tx_byte, e);
        tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask

    task automatic flag_check(input string req, input int code, input int lvl);
        logic [7:0] v;
        wr(3'd2, 8'h00);
        rd(3'd2, v);
        chk(req, v, flags_exp(code, lvl, 1'b0));
    endtask

    initial begin
        logic [7:0] v;
        int code, lvl, k;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(3'd5, v); chk("R1 reset tx count", v, 8'd0);
        rd(3'd4, v); chk("R1 reset rx count", v, 8'd0);
        rd(3'd1, v); chk("R4 reset control", v, 8'd0);
        chk("R9 reset irq", {7'b0, fifo_irq}, 8'd0);
        rd(3'd2, v); chk("R6 status after reset", v, 8'h01);

        // R2 fill and overflow
        for (int i = 0; i < 17; i++) cpu_push(8'($urandom));
        rd(3'd5, v); chk("R2 tx count after overflow", v, 8'd16);

        // R6 / R10: drain under each transmit code
        for (int rep = 0; rep < 4; rep++) begin
            code = rep;
            lvl  = 15;
            wr(3'd1, {4'(lvl), 2'(code), 2'b00});
            rd(3'd1, v); chk("R4 control readback", v, {4'(lvl), 2'(code), 2'b00});
            if (rep > 0) begin
                k = 9 + ($urandom % 8);
                for (int i = 0; i < k; i++) cpu_push(8'($urandom));
            end
            while (txq.size() > 0) begin
                flag_check("R6 tx low flag", code, lvl);
                eng_take("R10");
            end
            flag_check("R6 tx low flag empty", code, lvl);
        end
        rd(3'd5, v); chk("R1 tx count drained", v, 8'd0);

        // R7 transmit end
        @(negedge clk); tx_shift_done = 1'b1;
        @(negedge clk); tx_shift_done = 1'b0;
        rd(3'd2, v); chk("R7 tx end set", v & 8'h04, 8'h04);
        cpu_push(8'hA5);
        cpu_push(8'h5A);
        repeat (2) @(negedge clk);
        rd(3'd2, v); chk("R7 tx end sticky after push", v & 8'h04, 8'h04);
        wr(3'd2, 8'h04);
        rd(3'd2, v); chk("R8 written 1 keeps tx end", v & 8'h04, 8'h04);
        wr(3'd2, 8'h03);
        rd(3'd2, v); chk("R8 written 0 clears tx end", v & 8'h04, 8'h00);
        eng_take("R10");
        eng_take("R10");
        @(negedge clk); tx_shift_done = 1'b1;
        @(negedge clk); tx_shift_done = 1'b0;
        rd(3'd2, v); chk("R7 tx end on final shift", v & 8'h04, 8'h04);
        wr(3'd2, 8'h00);
        cpu_push(8'h11);
        @(negedge clk); tx_shift_done = 1'b1;
        @(negedge clk); tx_shift_done = 1'b0;
        rd(3'd2, v); chk("R7 no tx end while queue holds data", v & 8'h04, 8'h00);
        wr(3'd1, 8'h01); txq.delete();

        // R5 receive trigger, several levels
        for (int rep = 0; rep < 3; rep++) begin
            lvl = (rep == 0) ? 0 : (rep == 1) ? 15 : int'($urandom % 15);
            code = 3;
            wr(3'd1, {4'(lvl), 2'(code), 2'b00});
            for (int i = 0; i < 17; i++) begin
                eng_rx(8'($urandom));
                flag_check("R5 rx ready flag", code, lvl);
            end
            rd(3'd4, v); chk("R10 rx count after overflow", v, 8'd16);
            while (rxq.size() > 0) begin
                logic [7:0] e;
                e = rxq.pop_front();
                rd(3'd0, v); chk("R3 rx data order", v, e);
            end
            rd(3'd0, v); chk("R3 empty read returns 0", v, 8'd0);
            rd(3'd4, v); chk("R3 empty read keeps count", v, 8'd0);
        end

        // R4 flushes
        for (int i = 0; i < 3; i++) cpu_push(8'($urandom));
        for (int i = 0; i < 5; i++) eng_rx(8'($urandom));
        wr(3'd1, 8'h01); txq.delete();
        rd(3'd5, v); chk("R4 tx flushed", v, 8'd0);
        rd(3'd4, v); chk("R4 rx untouched by tx flush", v, 8'd5);
        cpu_push(8'h77);
        wr(3'd1, 8'h02); rxq.delete();
        rd(3'd4, v); chk("R4 rx flushed", v, 8'd0);
        rd(3'd5, v); chk("R4 tx untouched by rx flush", v, 8'd1);
        wr(3'd1, 8'h01); txq.delete();

        // R9 interrupt gating (control 0: tx code 0, n = 0)
        eng_rx(8'h3C);
        wr(3'd3, 8'h00); wr(3'd2, 8'h00);
        @(negedge clk);
        chk("R9 irq masked", {7'b0, fifo_irq}, 8'd0);
        wr(3'd3, 8'h02);
        @(negedge clk);
        chk("R9 irq on rx ready", {7'b0, fifo_irq}, 8'd1);
        rd(3'd0, v); rxq.delete();
        wr(3'd2, 8'h00);
        @(negedge clk);
        chk("R9 irq drops with rx flag", {7'b0, fifo_irq}, 8'd0);
        wr(3'd3, 8'h01);
        @(negedge clk);
        chk("R9 irq on tx low", {7'b0, fifo_irq}, 8'd1);
        rd(3'd3, v); chk("R9 enable readback", v, 8'h01);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule